// File: doc/BRIEF.md
# Fixed-Density Sparse Dot-Product Unit

This processing element multiplies a dense block of signed 8-bit activations by a weight block that has been compressed to a fixed density. Only the non-zero weights are stored, and each one carries the position it held in the uncompressed block. The unit has one multiply lane per stored weight, so the number of multipliers follows the non-zero count and not the block size. Each lane uses its position index to pick the matching activation out of the block, multiplies it by its weight, and all lane products go into one shared 32-bit signed accumulator. A new block can enter on every cycle.

The density is fixed when the block is built. The defaults give eight activations and four lanes, and a two-lane, four-activation build is also supported. A block with fewer non-zeros than lanes fills the spare lanes with zero weights. Blocks with more non-zeros than lanes cannot be expressed. A clear flag sent with a block starts a new sum, so the previous total is not added to it.

Top module: `sparse_dot_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no valid block, `acc_out` is 0 and `acc_valid` is 0.
- R2: Lane l takes its weight from `wt_nz[l*8 +: 8]` and its index from `wt_idx[l*IDX_W +: IDX_W]`. It multiplies that weight by the activation at position p = index, and position p sits at `act_blk[p*8 +: 8]`.
- R3: Activations and weights are two's-complement. Products are signed 16-bit values, sign-extended to 32 bits before they are summed. Four lanes of -128 x -128 give +65536.
- R4: A valid block with `in_clear` low adds the sum of all lane products to the accumulator.
- R5: A valid block with `in_clear` high loads the accumulator with that block's sum, and the earlier total is dropped.
- R6: While `in_valid` is low, `acc_out` does not change and `acc_valid` stays low, whatever the other inputs do.
- R7: A block presented on the clock edge k updates `acc_out` on edge k+2, and `acc_valid` is high for exactly that one cycle. Blocks sent back to back produce one update per cycle.
- R8: A lane whose weight is zero adds nothing, whatever its index selects.
- R9: Several lanes may carry the same index. Each one then multiplies the same activation and each product counts.
- R10: The two-lane, four-activation build (2-bit indices) gives the correct dot product for every combination of indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | A block is presented this cycle |
| in_clear | input | 1 | Load the accumulator with this block's sum instead of adding it |
| act_blk | input | BLOCK_SZ*8 | Dense activations; position p at bits p*8 +: 8 |
| wt_nz | input | LANES*8 | Non-zero weights, one per lane |
| wt_idx | input | LANES*IDX_W | Position index per lane |
| acc_out | output | 32 | Accumulator value |
| acc_valid | output | 1 | One-cycle pulse when `acc_out` has taken a block |

## Verification
The assertions check on every cycle the following properties:
- the accumulator holds its value when no block has arrived;
- an update happens two edges after the block was presented;
- each update equals either the previous value plus the lane sum, or the lane sum alone when the clear flag was set;
- a lane with a zero weight yields a zero product.

The assertions cannot show that a lane picks the right activation for its index, or that signed extremes and duplicate indices give the right numbers. The bench shows those with sweeps over every lane and every index of the default build, every index combination of the two-lane build, extreme signed operands and back-to-back streams, against dot products it computes itself.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // How a valid block updates the accumulator
  typedef enum logic {
    ACC_ADD  = 1'b0,
    ACC_LOAD = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/sdp_lane.sv
// One multiply lane: index-driven activation select followed by a signed multiply
module sdp_lane #(
  parameter int BLOCK_SZ = 8,
  parameter int OPND_W   = 8,
  parameter int IDX_W    = (BLOCK_SZ > 1) ? $clog2(BLOCK_SZ) : 1,
  parameter int PROD_W   = 2 * OPND_W
) (
  input  logic [BLOCK_SZ*OPND_W-1:0] act_i,
  input  logic [OPND_W-1:0]          wt_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic signed [PROD_W-1:0]   prod_o
);
  logic signed [OPND_W-1:0] act_sel;
  logic signed [OPND_W-1:0] wt_s;

  always_comb begin
    act_sel = act_i[idx_i*OPND_W +: OPND_W];
    wt_s    = wt_i;
    prod_o  = act_sel * wt_s;
    // R8
    if (wt_i == '0) begin
      zero_weight_chk: assert (prod_o == '0);
    end
  end
endmodule

// File: rtl/sdp_sum.sv
// Sign-extends every lane product and adds them into one accumulator-width value
module sdp_sum #(
  parameter int LANES  = 4,
  parameter int PROD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic [LANES*PROD_W-1:0] prod_i,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam int EXT_W = ACC_W - PROD_W;

  logic [ACC_W-1:0] ext [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_ext
    assign ext[l] = {{EXT_W{prod_i[l*PROD_W+PROD_W-1]}}, prod_i[l*PROD_W +: PROD_W]};
  end

  always_comb begin
    sum_o = '0;
    for (int l = 0; l < LANES; l++) begin
      sum_o = sum_o + $signed(ext[l]);
    end
  end
endmodule

// File: rtl/sparse_dot_unit.sv
// Fixed-density sparse dot-product processing element
module sparse_dot_unit
  import sdp_pkg::*;
#(
  parameter int BLOCK_SZ = 8,
  parameter int LANES    = 4,
  parameter int OPND_W   = 8,
  parameter int ACC_W    = 32,
  localparam int IDX_W   = (BLOCK_SZ > 1) ? $clog2(BLOCK_SZ) : 1,
  localparam int PROD_W  = 2 * OPND_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_clear,
  input  logic [BLOCK_SZ*OPND_W-1:0] act_blk,
  input  logic [LANES*OPND_W-1:0]    wt_nz,
  input  logic [LANES*IDX_W-1:0]     wt_idx,
  output logic [ACC_W-1:0]           acc_out,
  output logic                       acc_valid
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // stage 1: input capture
  logic                       s1_valid_q, s1_valid_d;
  acc_mode_e                  s1_mode_q, s1_mode_d;
  logic [BLOCK_SZ*OPND_W-1:0] s1_act_q, s1_act_d;
  logic [LANES*OPND_W-1:0]    s1_wt_q, s1_wt_d;
  logic [LANES*IDX_W-1:0]     s1_idx_q, s1_idx_d;
  logic                       s1_en;

  always_comb begin
    s1_en      = in_valid;
    s1_valid_d = in_valid;
    s1_mode_d  = in_clear ? ACC_LOAD : ACC_ADD;
    s1_act_d   = act_blk;
    s1_wt_d    = wt_nz;
    s1_idx_d   = wt_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s1_mode_q  <= ACC_ADD;
      s1_act_q   <= '0;
      s1_wt_q    <= '0;
      s1_idx_q   <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (s1_en) begin
        s1_mode_q <= s1_mode_d;
        s1_act_q  <= s1_act_d;
        s1_wt_q   <= s1_wt_d;
        s1_idx_q  <= s1_idx_d;
      end
    end
  end

  // lanes
  logic [LANES*PROD_W-1:0] lane_prod;
  logic signed [ACC_W-1:0] lane_sum;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sdp_lane #(
      .BLOCK_SZ (BLOCK_SZ),
      .OPND_W   (OPND_W),
      .IDX_W    (IDX_W),
      .PROD_W   (PROD_W)
    ) u_lane (
      .act_i  (s1_act_q),
      .wt_i   (s1_wt_q[l*OPND_W +: OPND_W]),
      .idx_i  (s1_idx_q[l*IDX_W +: IDX_W]),
      .prod_o (lane_prod[l*PROD_W +: PROD_W])
    );
  end

  sdp_sum #(
    .LANES  (LANES),
    .PROD_W (PROD_W),
    .ACC_W  (ACC_W)
  ) u_sum (
    .prod_i (lane_prod),
    .sum_o  (lane_sum)
  );

  // stage 2: shared accumulator
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_valid_q, acc_valid_d;
  logic             acc_en;

  always_comb begin
    acc_en      = s1_valid_q;
    acc_valid_d = s1_valid_q;
    acc_d       = (s1_mode_q == ACC_LOAD) ? lane_sum : (acc_q + lane_sum);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q       <= '0;
      acc_valid_q <= 1'b0;
    end else begin
      acc_valid_q <= acc_valid_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign acc_out   = acc_q;
  assign acc_valid = acc_valid_q;

  // R7
  update_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_valid |-> $past(in_valid, 2));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |-> $stable(acc_out));

  // R4
  add_update_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid_q && s1_mode_q == ACC_ADD) |=> acc_out == $past(acc_out) + $past(lane_sum));

  // R5
  load_update_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s1_valid_q && s1_mode_q == ACC_LOAD) |=> acc_out == $past(lane_sum));
endmodule

// File: tb/sparse_dot_unit_bench.sv
module sparse_dot_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n;

  // default build: 8 activations, 4 lanes, 3-bit indices
  logic        v8, c8;
  logic [63:0] a8;
  logic [31:0] w8;
  logic [11:0] i8;
  logic [31:0] r8;
  logic        rv8;

  // half build: 4 activations, 2 lanes, 2-bit indices
  logic        v4, c4;
  logic [31:0] a4;
  logic [15:0] w4;
  logic [3:0]  i4;
  logic [31:0] r4;
  logic        rv4;

  sparse_dot_unit u_sparse_dot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_clear(c8),
    .act_blk(a8), .wt_nz(w8), .wt_idx(i8), .acc_out(r8), .acc_valid(rv8));

  sparse_dot_unit #(.BLOCK_SZ(4), .LANES(2)) u_sparse_dot_unit_b4 (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_clear(c4),
    .act_blk(a4), .wt_nz(w4), .wt_idx(i4), .acc_out(r4), .acc_valid(rv4));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic signed [31:0] exp8 = 0;
  logic signed [31:0] exp4 = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic signed [31:0] dot8(input logic [63:0] a, input logic [31:0] w,
                                              input logic [11:0] ix);
    logic signed [31:0] s = 0;
    for (int l = 0; l < 4; l++) begin
      logic signed [7:0] wv, av;
      wv = w[l*8 +: 8];
      av = a[ix[l*3 +: 3]*8 +: 8];
      s = s + wv * av;
    end
    return s;
  endfunction

  function automatic logic signed [31:0] dot4(input logic [31:0] a, input logic [15:0] w,
                                              input logic [3:0] ix);
    logic signed [31:0] s = 0;
    for (int l = 0; l < 2; l++) begin
      logic signed [7:0] wv, av;
      wv = w[l*8 +: 8];
      av = a[ix[l*2 +: 2]*8 +: 8];
      s = s + wv * av;
    end
    return s;
  endfunction

  task automatic blk8(input logic [63:0] a, input logic [31:0] w, input logic [11:0] ix,
                      input bit clr, input string req);
    logic signed [31:0] d;
    @(negedge clk);
    a8 = a; w8 = w; i8 = ix; c8 = clr; v8 = 1'b1;
    d = dot8(a, w, ix);
    exp8 = clr ? d : exp8 + d;
    @(negedge clk);
    v8 = 1'b0;
    chk("R7 no early valid", {31'b0, rv8}, 32'd0);
    @(negedge clk);
    chk("R7 valid pulse", {31'b0, rv8}, 32'd1);
    chk(req, r8, exp8);
  endtask

  task automatic blk4(input logic [31:0] a, input logic [15:0] w, input logic [3:0] ix,
                      input bit clr, input string req);
    logic signed [31:0] d;
    @(negedge clk);
    a4 = a; w4 = w; i4 = ix; c4 = clr; v4 = 1'b1;
    d = dot4(a, w, ix);
    exp4 = clr ? d : exp4 + d;
    @(negedge clk);
    v4 = 1'b0;
    @(negedge clk);
    chk("R10 valid pulse", {31'b0, rv4}, 32'd1);
    chk(req, r4, exp4);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] sa [8];
    logic [31:0] sw [8];
    logic [11:0] si [8];
    logic signed [31:0] sexp [8];
    logic signed [31:0] run;
    logic [31:0] hold;

    rst_n = 1'b0;
    v8 = 0; c8 = 0; a8 = '0; w8 = '0; i8 = '0;
    v4 = 0; c4 = 0; a4 = '0; w4 = '0; i4 = '0;
    repeat (3) @(negedge clk);
    chk("R1 acc in reset", r8, 32'd0);
    chk("R1 valid in reset", {31'b0, rv8}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 acc after release", r8, 32'd0);
    chk("R1 valid after release", {31'b0, rv8}, 32'd0);

    // R2: every lane, every position; activation at position p is p+1
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 8; p++) begin
        logic [63:0] a;
        logic [11:0] ix;
        for (int q = 0; q < 8; q++) a[q*8 +: 8] = 8'(q + 1);
        ix = 12'($urandom);
        ix[l*3 +: 3] = 3'(p);
        blk8(a, 32'(1) << (l*8), ix, 1'b1, "R2 lane select");
        chk("R2 value is position+1", r8, 32'(p + 1));
      end
    end

    // R3: signed extremes
    blk8({8{8'h80}}, {4{8'h80}}, 12'h000, 1'b1, "R3 min x min");
    chk("R3 four lanes of -128*-128", r8, 32'd65536);
    blk8({8{8'h80}}, {4{8'h7F}}, 12'hFFF, 1'b1, "R3 min x max");
    chk("R3 four lanes of -128*127", r8, -32'sd65024);
    blk8({8{8'hFF}}, {4{8'h01}}, 12'h555, 1'b1, "R3 minus one");

    // R4 and R5: random accumulation with occasional clear
    for (int k = 0; k < 200; k++) begin
      bit clr;
      clr = (k % 17 == 0);
      blk8({$urandom, $urandom}, $urandom, 12'($urandom), clr, clr ? "R5 clear load" : "R4 accumulate");
    end

    // R8: zero weights leave the total unchanged
    hold = r8;
    blk8({$urandom, $urandom}, 32'd0, 12'($urandom), 1'b0, "R8 zero weights");
    chk("R8 total unchanged", r8, hold);

    // R9: duplicate indices
    blk8(64'h0000_0000_0500_0000, 32'h0403_0201, 12'b011_011_011_011, 1'b1, "R9 duplicate index");
    chk("R9 shared activation 5*(1+2+3+4)", r8, 32'd50);

    // R6: idle cycles with changing inputs
    hold = r8;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      a8 = {$urandom, $urandom}; w8 = $urandom; i8 = 12'($urandom); c8 = 1'b1;
      chk("R6 acc held", r8, hold);
      chk("R6 no valid", {31'b0, rv8}, 32'd0);
    end
    c8 = 1'b0;

    // R7: back-to-back stream
    run = exp8;
    for (int k = 0; k < 8; k++) begin
      sa[k] = {$urandom, $urandom}; sw[k] = $urandom; si[k] = 12'($urandom);
      run = (k == 0) ? dot8(sa[k], sw[k], si[k]) : run + dot8(sa[k], sw[k], si[k]);
      sexp[k] = run;
    end
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R7 stream valid", {31'b0, rv8}, 32'd1);
        chk("R7 stream value", r8, sexp[k-2]);
      end
      if (k < 8) begin
        a8 = sa[k]; w8 = sw[k]; i8 = si[k]; c8 = (k == 0); v8 = 1'b1;
      end else begin
        v8 = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 stream ends", {31'b0, rv8}, 32'd0);
    exp8 = sexp[7];

    // R10: half build, every index combination under several operand sets
    for (int s = 0; s < 4; s++) begin
      for (int ix = 0; ix < 16; ix++) begin
        logic [31:0] a;
        logic [15:0] w;
        a = (s == 0) ? 32'h80_64_03_F9 : $urandom;
        w = (s == 0) ? 16'h7F_80 : 16'($urandom);
        blk4(a, w, 4'(ix), (ix % 5 == 0), "R10 half build");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule